// File: doc/BRIEF.md
# Caller ID Message Frame Parser

This block sits behind a 1200 bps asynchronous character receiver that listens to the validated demodulator stream of an on-hook data receiver. Each received character arrives as one byte on a single-cycle valid strobe. The parser walks a calling-number delivery message, checks its trailing checksum, and writes the fields it finds into a small register file that a display controller reads.

Two layouts are understood. In the single layout, the body holds eight ASCII date/time characters and then the digits of the calling number. In the multiple layout, the body is a chain of records, each made of a record code, a record length and that many bytes. The time stamp, the number and the caller name are picked out of these records, and all other records are stepped over. Messages with any other type code are skipped by their length. If the line goes quiet for too long in the middle of a message, the partial frame is dropped and the parser waits for a fresh message.

Top module: `cid_frame_parser`

## Requirements
- R1: After reset, msg_done and cks_err are low, msg_kind is 0, and every field output and count is zero.
- R2: A message whose first byte is 0x04 sets msg_kind to 1. Body bytes 0..7 go to stamp_chars, with body byte i at bits [8i+7:8i]. Later body bytes are appended to num_chars, with digit k at bits [8k+7:8k], and num_count counts them.
- R3: A message whose first byte is 0x80 sets msg_kind to 2 and parses records of (code, length, data). Code 0x01 writes stamp_chars by position within the record, code 0x02 appends to num_chars, code 0x07 appends to name_chars (name byte j at bits [8j+7:8j]), and any other code is stepped over without writes.
- R4: The byte after the length-counted body is the checksum. msg_done pulses high for exactly one cycle after that byte is accepted. In the same cycle, cks_err becomes 1 if the modulo-256 sum of all message bytes, checksum included, is non-zero, and 0 otherwise. cks_err holds that value until the next message begins.
- R5: Any other first byte sets msg_kind to 3. The parser skips the counted body, checks the checksum and pulses msg_done, and leaves all field outputs and counts unchanged.
- R6: When a message is in progress and GAP_CYCLES consecutive clock edges pass with no accepted byte, the frame is aborted without msg_done. The next byte is then treated as a message type byte. A byte arriving on the GAP_CYCLES-th edge is still accepted.
- R7: Number digits beyond NUM_MAX and name characters beyond NAME_MAX are dropped. num_count and name_count saturate at those limits.
- R8: A message length of zero makes the very next byte the checksum.
- R9: When the message length runs out inside a record, the next byte is taken as the checksum, and the bytes already stored are kept.
- R10: Field outputs and counts are cleared when a type 0x04 or 0x80 byte is accepted. They do not change between msg_done and the next message's first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | One received byte present this cycle |
| byte_data | input | 8 | Received byte |
| msg_done | output | 1 | One-cycle pulse after a complete message |
| cks_err | output | 1 | Checksum of the last completed message was bad |
| msg_kind | output | 2 | 0 none, 1 single, 2 multiple, 3 other |
| stamp_chars | output | 64 | Eight date/time ASCII characters |
| num_chars | output | NUM_MAX*8 | Calling number digits |
| num_count | output | $clog2(NUM_MAX+1) | Number of stored digits |
| name_chars | output | NAME_MAX*8 | Caller name characters |
| name_count | output | $clog2(NAME_MAX+1) | Number of stored name characters |

## Verification
The hardest situation to reach is the silence timeout at its exact edge. A byte that lands on the last permitted edge must be accepted, and one that lands a single edge later must start a new message. The bench sets a short silence limit and inserts idle stretches of exactly GAP_CYCLES-2 and GAP_CYCLES-1 cycles inside a frame. It then checks whether the following bytes complete the old frame or form a fresh one. Truncated records and saturating counts are reached by sweeping the body and name lengths across the store limits, with every fourth or third frame given a corrupted checksum.

// File: rtl/cid_pkg.sv
`timescale 1ns/1ps
package cid_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LEN, ST_BODY, ST_PTYPE, ST_PLEN, ST_PDATA, ST_CKS
    } prs_state_e;

    typedef enum logic [1:0] {
        KIND_NONE   = 2'd0,
        KIND_SINGLE = 2'd1,
        KIND_MULTI  = 2'd2,
        KIND_OTHER  = 2'd3
    } msg_kind_e;

    typedef enum logic [1:0] {
        TGT_SKIP, TGT_STAMP, TGT_NUMBER, TGT_NAME
    } fld_tgt_e;

    localparam logic [7:0] CODE_SINGLE = 8'h04;
    localparam logic [7:0] CODE_MULTI  = 8'h80;
    localparam logic [7:0] PRM_STAMP   = 8'h01;
    localparam logic [7:0] PRM_NUMBER  = 8'h02;
    localparam logic [7:0] PRM_NAME    = 8'h07;
    localparam int         STAMP_BYTES = 8;

    typedef struct packed {
        prs_state_e st;
        msg_kind_e  kind;
        logic [7:0] rem;
        logic [7:0] prem;
        logic [7:0] idx;
        fld_tgt_e   tgt;
        logic       done;
        logic       err;
    } prs_reg_t;

endpackage

// File: rtl/cid_gap_timer.sv
`timescale 1ns/1ps
module cid_gap_timer #(
    parameter int GAP_CYCLES = 1_200_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic byte_vld,
    output logic expire
);
    localparam int CW = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
    localparam logic [CW-1:0] LIM = CW'(GAP_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = active && !byte_vld && (cnt_q == LIM);
        if (!active || byte_vld || expire) cnt_d = '0;
        else                               cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    p_gap_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM);
    p_gap_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> (cnt_q == '0));

endmodule

// File: rtl/cid_sum_acc.sv
`timescale 1ns/1ps
module cid_sum_acc (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       add,
    input  logic [7:0] din,
    output logic       total_zero
);
    logic [7:0] sum_d, sum_q;

    always_comb begin
        if (load)     sum_d = din;
        else if (add) sum_d = sum_q + din;
        else          sum_d = sum_q;
        total_zero = ((sum_q + din) == 8'h00);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end

endmodule

// File: rtl/cid_field_file.sv
`timescale 1ns/1ps
module cid_field_file
    import cid_pkg::*;
#(
    parameter int NUM_MAX  = 10,
    parameter int NAME_MAX = 15
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear,
    input  logic                          wr_en,
    input  fld_tgt_e                      wr_tgt,
    input  logic [7:0]                    wr_idx,
    input  logic [7:0]                    wr_data,
    output logic [STAMP_BYTES*8-1:0]      stamp_o,
    output logic [NUM_MAX*8-1:0]          num_o,
    output logic [$clog2(NUM_MAX+1)-1:0]  num_cnt_o,
    output logic [NAME_MAX*8-1:0]         name_o,
    output logic [$clog2(NAME_MAX+1)-1:0] name_cnt_o
);
    localparam int NUM_LW  = $clog2(NUM_MAX + 1);
    localparam int NAME_LW = $clog2(NAME_MAX + 1);
    localparam logic [NUM_LW-1:0]  NUM_CAP  = NUM_LW'(NUM_MAX);
    localparam logic [NAME_LW-1:0] NAME_CAP = NAME_LW'(NAME_MAX);
    localparam logic [7:0]         STAMP_CAP = 8'(STAMP_BYTES);

    typedef struct packed {
        logic [STAMP_BYTES-1:0][7:0] stamp;
        logic [NUM_MAX-1:0][7:0]     num;
        logic [NUM_LW-1:0]           num_cnt;
        logic [NAME_MAX-1:0][7:0]    name;
        logic [NAME_LW-1:0]          name_cnt;
    } ff_t;

    ff_t ff_d, ff_q;

    always_comb begin
        ff_d = ff_q;
        if (clear) begin
            ff_d = '0;
        end else if (wr_en) begin
            case (wr_tgt)
                TGT_STAMP: begin
                    if (wr_idx < STAMP_CAP) ff_d.stamp[wr_idx[2:0]] = wr_data;
                end
                TGT_NUMBER: begin
                    if (ff_q.num_cnt < NUM_CAP) begin
                        ff_d.num[ff_q.num_cnt] = wr_data;
                        ff_d.num_cnt           = ff_q.num_cnt + 1'b1;
                    end
                end
                TGT_NAME: begin
                    if (ff_q.name_cnt < NAME_CAP) begin
                        ff_d.name[ff_q.name_cnt] = wr_data;
                        ff_d.name_cnt            = ff_q.name_cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '0;
        else        ff_q <= ff_d;
    end

    assign stamp_o    = ff_q.stamp;
    assign num_o      = ff_q.num;
    assign num_cnt_o  = ff_q.num_cnt;
    assign name_o     = ff_q.name;
    assign name_cnt_o = ff_q.name_cnt;

    p_num_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ff_q.num_cnt <= NUM_CAP);
    p_name_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ff_q.name_cnt <= NAME_CAP);
    p_quiet_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !wr_en) |=> $stable(ff_q));

endmodule

// File: rtl/cid_frame_parser.sv
`timescale 1ns/1ps
module cid_frame_parser
    import cid_pkg::*;
#(
    parameter int NUM_MAX    = 10,
    parameter int NAME_MAX   = 15,
    parameter int GAP_CYCLES = 1_200_000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          byte_vld,
    input  logic [7:0]                    byte_data,
    output logic                          msg_done,
    output logic                          cks_err,
    output logic [1:0]                    msg_kind,
    output logic [63:0]                   stamp_chars,
    output logic [NUM_MAX*8-1:0]          num_chars,
    output logic [$clog2(NUM_MAX+1)-1:0]  num_count,
    output logic [NAME_MAX*8-1:0]         name_chars,
    output logic [$clog2(NAME_MAX+1)-1:0] name_count
);
    prs_reg_t   q, d;
    logic       gap_expire;
    logic       sum_zero;
    logic       sum_load, sum_add;
    logic       fld_clr, fld_wr;
    fld_tgt_e   fld_tgt;
    logic [7:0] fld_idx;

    cid_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (q.st != ST_IDLE),
        .byte_vld (byte_vld),
        .expire   (gap_expire)
    );

    cid_sum_acc u_sum (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (sum_load),
        .add        (sum_add),
        .din        (byte_data),
        .total_zero (sum_zero)
    );

    cid_field_file #(.NUM_MAX(NUM_MAX), .NAME_MAX(NAME_MAX)) u_fields (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (fld_clr),
        .wr_en      (fld_wr),
        .wr_tgt     (fld_tgt),
        .wr_idx     (fld_idx),
        .wr_data    (byte_data),
        .stamp_o    (stamp_chars),
        .num_o      (num_chars),
        .num_cnt_o  (num_count),
        .name_o     (name_chars),
        .name_cnt_o (name_count)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        sum_load = 1'b0;
        sum_add  = 1'b0;
        fld_clr  = 1'b0;
        fld_wr   = 1'b0;
        fld_tgt  = TGT_SKIP;
        fld_idx  = q.idx;

        if (gap_expire) begin
            d.st = ST_IDLE;
        end else if (byte_vld) begin
            sum_add = (q.st != ST_IDLE);
            case (q.st)
                ST_IDLE: begin
                    sum_load = 1'b1;
                    d.err    = 1'b0;
                    d.st     = ST_LEN;
                    case (byte_data)
                        CODE_SINGLE: d.kind = KIND_SINGLE;
                        CODE_MULTI:  d.kind = KIND_MULTI;
                        default:     d.kind = KIND_OTHER;
                    endcase
                    fld_clr = (byte_data == CODE_SINGLE) || (byte_data == CODE_MULTI);
                end
                ST_LEN: begin
                    d.rem = byte_data;
                    d.idx = '0;
                    if (byte_data == 8'd0)        d.st = ST_CKS;
                    else if (q.kind == KIND_MULTI) d.st = ST_PTYPE;
                    else                           d.st = ST_BODY;
                end
                ST_BODY: begin
                    d.rem = q.rem - 1'b1;
                    d.idx = q.idx + 1'b1;
                    if (q.kind == KIND_SINGLE) begin
                        fld_wr  = 1'b1;
                        fld_tgt = (q.idx < 8'(STAMP_BYTES)) ? TGT_STAMP : TGT_NUMBER;
                    end
                    if (q.rem == 8'd1) d.st = ST_CKS;
                end
                ST_PTYPE: begin
                    d.rem = q.rem - 1'b1;
                    case (byte_data)
                        PRM_STAMP:  d.tgt = TGT_STAMP;
                        PRM_NUMBER: d.tgt = TGT_NUMBER;
                        PRM_NAME:   d.tgt = TGT_NAME;
                        default:    d.tgt = TGT_SKIP;
                    endcase
                    d.st = (q.rem == 8'd1) ? ST_CKS : ST_PLEN;
                end
                ST_PLEN: begin
                    d.rem  = q.rem - 1'b1;
                    d.prem = byte_data;
                    d.idx  = '0;
                    if (q.rem == 8'd1)          d.st = ST_CKS;
                    else if (byte_data == 8'd0) d.st = ST_PTYPE;
                    else                        d.st = ST_PDATA;
                end
                ST_PDATA: begin
                    d.rem   = q.rem - 1'b1;
                    d.prem  = q.prem - 1'b1;
                    d.idx   = q.idx + 1'b1;
                    fld_wr  = (q.tgt != TGT_SKIP);
                    fld_tgt = q.tgt;
                    if (q.rem == 8'd1)       d.st = ST_CKS;
                    else if (q.prem == 8'd1) d.st = ST_PTYPE;
                end
                ST_CKS: begin
                    d.done = 1'b1;
                    d.err  = !sum_zero;
                    d.st   = ST_IDLE;
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.kind <= KIND_NONE;
            q.tgt  <= TGT_SKIP;
        end else begin
            q <= d;
        end
    end

    assign msg_done = q.done;
    assign cks_err  = q.err;
    assign msg_kind = q.kind;

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        msg_done |=> !msg_done);
    p_done_follows_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_done) |-> $past(byte_vld));
    p_err_at_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cks_err) |-> msg_done);
    p_abort_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        gap_expire |=> (q.st == ST_IDLE && !msg_done));
    p_other_untouched_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.kind == KIND_OTHER && q.st != ST_IDLE) |=>
            ($stable(num_chars) && $stable(name_chars) && $stable(stamp_chars)));

endmodule

// File: tb/test_cid_frame_parser.sv
`timescale 1ns/1ps
module test_cid_frame_parser;
    localparam int NUM_MAX  = 10;
    localparam int NAME_MAX = 15;
    localparam int GAP      = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic byte_vld = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic msg_done, cks_err;
    logic [1:0] msg_kind;
    logic [63:0] stamp_chars;
    logic [NUM_MAX*8-1:0] num_chars;
    logic [3:0] num_count;
    logic [NAME_MAX*8-1:0] name_chars;
    logic [3:0] name_count;

    always #5 clk = ~clk;

    cid_frame_parser #(.NUM_MAX(NUM_MAX), .NAME_MAX(NAME_MAX), .GAP_CYCLES(GAP)) i_cid_frame_parser (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
        .msg_done(msg_done), .cks_err(cks_err), .msg_kind(msg_kind),
        .stamp_chars(stamp_chars), .num_chars(num_chars), .num_count(num_count),
        .name_chars(name_chars), .name_count(name_count)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [7:0] fb [0:127];
    int fn;
    logic [63:0]  e_stamp;
    logic [79:0]  e_num;
    logic [119:0] e_name;
    int e_nc, e_mc;

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_byte(logic [7:0] b, int idle);
        @(negedge clk); byte_vld = 1'b1; byte_data = b;
        @(negedge clk); byte_vld = 1'b0;
        repeat (idle) @(negedge clk);
    endtask

    task automatic add(logic [7:0] b);
        fb[fn] = b; fn++;
    endtask

    task automatic seal(bit bad);
        logic [7:0] s;
        fb[1] = 8'(fn - 2);
        s = 8'h00;
        for (int i = 0; i < fn; i++) s = s + fb[i];
        add(8'(8'h00 - s) + (bad ? 8'h01 : 8'h00));
    endtask

    task automatic send();
        for (int i = 0; i < fn; i++) put_byte(fb[i], 0);
    endtask

    task automatic clr_exp();
        e_stamp = '0; e_num = '0; e_name = '0; e_nc = 0; e_mc = 0;
    endtask

    task automatic check_fields(string tag);
        chk({tag, " stamp"}, 128'(stamp_chars), 128'(e_stamp));
        chk({tag, " num"},   128'(num_chars),   128'(e_num));
        chk({tag, " ncnt"},  128'(num_count),   128'(e_nc));
        chk({tag, " name"},  128'(name_chars),  128'(e_name));
        chk({tag, " mcnt"},  128'(name_count),  128'(e_mc));
    endtask

    task automatic check_end(string tag, int kind, bit err);
        chk({tag, " done"}, 128'(msg_done), 128'(1));
        chk({tag, " kind"}, 128'(msg_kind), 128'(kind));
        chk({tag, " err"},  128'(cks_err),  128'(err));
        check_fields(tag);
        @(negedge clk);
        chk({tag, " done pulse"}, 128'(msg_done), 128'(0));
    endtask

    task automatic build_single(int nd, bit bad);
        logic [7:0] c;
        fn = 0; clr_exp();
        add(8'h04); add(8'h00);
        for (int i = 0; i < 8; i++) begin
            c = 8'(8'h30 + (i + nd) % 10); add(c); e_stamp[i*8 +: 8] = c;
        end
        for (int k = 0; k < nd; k++) begin
            c = 8'(8'h30 + (3*k + nd) % 10); add(c);
            if (k < NUM_MAX) begin e_num[k*8 +: 8] = c; e_nc = k + 1; end
        end
        seal(bad);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] c;
        repeat (3) @(negedge clk);
        clr_exp();
        // R1: reset state
        chk("R1 done", 128'(msg_done), 128'(0));
        chk("R1 err",  128'(cks_err),  128'(0));
        chk("R1 kind", 128'(msg_kind), 128'(0));
        check_fields("R1");
        rst_n = 1'b1;

        // R2, R4, R7: single format sweep over digit counts
        for (int nd = 0; nd <= 12; nd++) begin
            build_single(nd, (nd % 4) == 1);
            send();
            check_end($sformatf("R2/R4/R7 single nd=%0d", nd), 1, (nd % 4) == 1);
        end

        // R10: outputs hold after completion
        repeat (7) @(negedge clk);
        chk("R10 hold kind", 128'(msg_kind), 128'(1));
        chk("R10 hold err",  128'(cks_err),  128'(0));
        check_fields("R10 hold");

        // R5: unknown type skipped, fields unchanged
        for (int u = 0; u < 2; u++) begin
            fn = 0; add(8'h55 + 8'(u)); add(8'h00);
            for (int i = 0; i < 5 + u; i++) add(8'h02);
            seal(u == 1);
            send();
            check_end($sformatf("R5 other u=%0d", u), 3, u == 1);
        end

        // R3, R7: multiple format sweep over name lengths
        for (int nl = 0; nl <= 17; nl++) begin
            fn = 0; clr_exp();
            add(8'h80); add(8'h00);
            add(8'h01); add(8'd8);
            for (int i = 0; i < 8; i++) begin
                c = 8'(8'h30 + (i + nl) % 10); add(c); e_stamp[i*8 +: 8] = c;
            end
            add(8'h02); add(8'd7);
            for (int k = 0; k < 7; k++) begin
                c = 8'(8'h30 + (k + nl) % 10); add(c); e_num[k*8 +: 8] = c;
            end
            e_nc = 7;
            add(8'h05); add(8'd3); add(8'h61); add(8'h62); add(8'h63);
            add(8'h07); add(8'(nl));
            for (int j = 0; j < nl; j++) begin
                c = 8'(8'h41 + (j + nl) % 26); add(c);
                if (j < NAME_MAX) begin e_name[j*8 +: 8] = c; e_mc = j + 1; end
            end
            seal((nl % 3) == 0);
            send();
            check_end($sformatf("R3/R7 multi nl=%0d", nl), 2, (nl % 3) == 0);
        end

        // R8: zero-length body
        fn = 0; clr_exp(); add(8'h04); add(8'h00); seal(0); send();
        check_end("R8 zero length", 1, 0);

        // R9: record cut short by message length
        fn = 0; clr_exp(); add(8'h80); add(8'h00); add(8'h02); add(8'd6);
        add(8'h31); add(8'h32); seal(0);
        e_num[7:0] = 8'h31; e_num[15:8] = 8'h32; e_nc = 2;
        send();
        check_end("R9 truncated record", 2, 0);

        // R6: gap on the last permitted edge keeps the frame
        build_single(3, 0);
        for (int i = 0; i < fn; i++) put_byte(fb[i], (i == 5) ? GAP - 2 : 0);
        check_end("R6 gap accepted", 1, 0);

        // R6: one edge longer aborts; a fresh frame follows
        put_byte(8'h04, 0); put_byte(8'd10, 0); put_byte(8'h31, 0);
        put_byte(8'h32, GAP - 1);
        chk("R6 abort no done", 128'(msg_done), 128'(0));
        build_single(4, 0);
        send();
        check_end("R6 after abort", 1, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule